// File: doc/BRIEF.md
# Core Operating-Point Transition Sequencer

This block moves a processor core from one operating point to another. An operating point pairs a core clock multiplier (the ratio) with a supply-voltage request code (the VID). Software starts a move by writing a target point into a register. The sequencer compares the target with the point it drives now. It then changes the two outputs in an order that keeps the core safe. When the frequency goes up, the voltage rises first. When the frequency goes down, the voltage falls last.

The VID output moves one code per step. One code equals 12.5 mV, and a higher code asks for a higher voltage. Software sets a dwell count that spaces the steps, so the regulator has time to settle. After every ratio change the block waits a fixed relock period before it acts again. The block has no bus-clock output, so only the core multiplier can change. A busy flag covers the whole move. A write made while the block is busy is dropped, and it sets a sticky error bit.

Top module: `vfstep_ctrl`

## Requirements
- R1: After reset, `vid_out` is 0, `ratio_out` is `RATIO_RESET` (6), and `busy`, `done` and `err` are all 0.
- R2: A move starts only when software writes register address 0. The VID field sits in `wr_data[VID_W-1:0]` and the ratio field in `wr_data[8+RATIO_W-1:8]`. Without such a write, `vid_out` and `ratio_out` hold their values.
- R3: If the target ratio is above the current ratio, the VID steps all the way to its target first. The ratio then changes DWELL+2 cycles after the last VID step.
- R4: If the target ratio is below the current ratio, the ratio changes first. The first VID step comes RELOCK_CYC+1 cycles after the ratio change.
- R5: Every change of `vid_out` is exactly one code, up or down.
- R6: Two successive VID steps within one move are DWELL+1 cycles apart. DWELL is the value written to address 1, bits [7:0], and it may be 0.
- R7: If the target ratio equals the current ratio, only the VID steps and `ratio_out` never changes.
- R8: If the target equals the current point, `done` is 1 on the next cycle, `busy` stays 0 and neither output changes.
- R9: `busy` is 1 from the cycle after an accepted write until the move completes, and `done` is then set. `busy` and `done` are never 1 together.
- R10: A write to address 0 while `busy` is 1 is ignored and sets `err`. `err` stays set until any write to address 2.
- R11: The read port returns combinationally, from `rd_addr`:
  - address 1: the dwell value;
  - address 2: the status, with `busy` in bit 0, `done` in bit 1 and `err` in bit 2;
  - address 3: the current point, in the same field layout as the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 target, 1 dwell, 2 status clear) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data |
| vid_out | output | VID_W | Voltage request code to the regulator |
| ratio_out | output | RATIO_W | Core clock multiplier |
| busy | output | 1 | Move in progress |
| done | output | 1 | Last accepted move has completed |
| err | output | 1 | Sticky flag for a write made while busy |

## Verification
The scoreboard predicts, for each move, the exact order of VID and ratio changes and the cycle gap between them. Each type of error therefore shows up as a wrong step or wrong spacing:
- A sequencer that used one order for both directions would change the ratio first on an up move, or last on a down move.
- Missing the relock wait or mishandling the dwell would shift the gaps, including the dwell-of-zero case where steps come every cycle.
- An equal-target write is checked to produce no output change and no busy pulse.
- A mixed move (ratio up, VID down) tests that the VID can step down inside an up move.
- A write made during a move is checked to leave the final point unchanged and to set a sticky error that only a status write clears.

// File: rtl/vfs_pkg.sv
// Package: shared state encoding and register addresses for the
// operating-point transition sequencer. Assumes a 2-bit register address.
package vfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,    // waiting for a target write
        ST_VOLT,    // stepping the VID toward its target
        ST_RATIO,   // applying the new core ratio
        ST_RELOCK   // fixed clock relock wait
    } vfs_state_e;

    localparam logic [1:0] ADDR_TARGET = 2'd0;
    localparam logic [1:0] ADDR_DWELL  = 2'd1;
    localparam logic [1:0] ADDR_STATUS = 2'd2;
    localparam logic [1:0] ADDR_POINT  = 2'd3;

    localparam int RATIO_LSB = 8;
endpackage

// File: rtl/vfs_timer.sv
// Module: down counter shared by the dwell and relock waits.
// Assumes a load takes priority over a decrement and that the count stops at zero.
module vfs_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    // Load a new count, or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/vfs_regs.sv
// Module: register file holding the dwell count and the sticky error bit,
// plus the read mux. Assumes the target fields are captured by the sequencer
// itself on the start pulse produced here.
module vfs_regs
    import vfs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int VID_W       = 6,
    parameter int RATIO_W     = 6,
    parameter int DWELL_W     = 8,
    parameter int DWELL_RESET = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               busy,
    input  logic               done,
    input  logic [VID_W-1:0]   cur_vid,
    input  logic [RATIO_W-1:0] cur_ratio,
    output logic               start,
    output logic [DWELL_W-1:0] dwell,
    output logic               err
);
    localparam int HI_PAD  = DATA_W - RATIO_LSB - RATIO_W;
    localparam int MID_PAD = RATIO_LSB - VID_W;

    logic tgt_wr;
    assign tgt_wr = wr_en && (wr_addr == ADDR_TARGET);
    assign start  = tgt_wr && !busy;

    // Hold the programmed dwell count.
    always_ff @(posedge clk) begin
        if (!rst_n)                                dwell <= DWELL_W'(DWELL_RESET);
        else if (wr_en && wr_addr == ADDR_DWELL)   dwell <= wr_data[DWELL_W-1:0];
    end

    // Sticky error: set by a target write while busy, cleared by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                err <= 1'b0;
        else if (tgt_wr && busy)                   err <= 1'b1;
        else if (wr_en && wr_addr == ADDR_STATUS)  err <= 1'b0;
    end

    // Combinational read mux.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_DWELL:  rd_data = {{(DATA_W-DWELL_W){1'b0}}, dwell};
            ADDR_STATUS: rd_data = {{(DATA_W-3){1'b0}}, err, done, busy};
            ADDR_POINT:  rd_data = {{HI_PAD{1'b0}}, cur_ratio, {MID_PAD{1'b0}}, cur_vid};
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/vfs_seq_fsm.sv
// Module: sequencing state machine. It latches the target, steps the VID one
// code at a time, applies the ratio and waits for relock. The order follows
// from the state flow. VOLT runs before RATIO only while the ratio still
// differs and the VID is not yet at its target. A down move enters RATIO
// directly. Assumes the timer reports zero one cycle after a load of zero.
module vfs_seq_fsm
    import vfs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int VID_W       = 6,
    parameter int RATIO_W     = 6,
    parameter int DWELL_W     = 8,
    parameter int TW          = 8,
    parameter int RELOCK_CYC  = 16,
    parameter int VID_RESET   = 0,
    parameter int RATIO_RESET = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DATA_W-1:0]  tgt_word,
    input  logic [DWELL_W-1:0] dwell,
    input  logic               tmr_zero,
    output logic               tmr_load,
    output logic [TW-1:0]      tmr_val,
    output logic [VID_W-1:0]   vid,
    output logic [RATIO_W-1:0] ratio,
    output logic               busy,
    output logic               done
);
    vfs_state_e         state_q;
    logic [VID_W-1:0]   tv_q;
    logic [RATIO_W-1:0] tr_q;
    logic [VID_W-1:0]   in_vid;
    logic [RATIO_W-1:0] in_ratio;

    assign in_vid   = tgt_word[VID_W-1:0];
    assign in_ratio = tgt_word[RATIO_LSB +: RATIO_W];

    // Decide when the shared timer is reloaded, and with what count.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE:   tmr_load = start;
            ST_VOLT:   if (tmr_zero && vid != tv_q) begin
                           tmr_load = 1'b1;
                           tmr_val  = TW'(dwell);
                       end
            ST_RATIO:  begin
                           tmr_load = 1'b1;
                           tmr_val  = TW'(RELOCK_CYC - 1);
                       end
            ST_RELOCK: tmr_load = tmr_zero;
            default:   tmr_load = 1'b0;
        endcase
    end

    // Advance the sequence and drive the operating-point outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vid     <= VID_W'(VID_RESET);
            ratio   <= RATIO_W'(RATIO_RESET);
            tv_q    <= VID_W'(VID_RESET);
            tr_q    <= RATIO_W'(RATIO_RESET);
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    tv_q <= in_vid;
                    tr_q <= in_ratio;
                    if (in_vid == vid && in_ratio == ratio) begin
                        done <= 1'b1;
                    end else begin
                        done    <= 1'b0;
                        busy    <= 1'b1;
                        state_q <= (in_ratio < ratio) ? ST_RATIO : ST_VOLT;
                    end
                end
                ST_VOLT: if (tmr_zero) begin
                    if (vid != tv_q) begin
                        vid <= (tv_q > vid) ? vid + 1'b1 : vid - 1'b1;
                    end else if (ratio != tr_q) begin
                        state_q <= ST_RATIO;
                    end else begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_RATIO: begin
                    ratio   <= tr_q;
                    state_q <= ST_RELOCK;
                end
                ST_RELOCK: if (tmr_zero) begin
                    if (vid != tv_q) begin
                        state_q <= ST_VOLT;
                    end else begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vfstep_ctrl.sv
// Module: top of the operating-point transition sequencer. It ties the
// register file, the sequencing state machine and the shared wait timer
// together. Assumes VID_W <= 8 and 8 + RATIO_W <= DATA_W, so that both target
// fields fit in one data word.
module vfstep_ctrl
    import vfs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int VID_W       = 6,
    parameter int RATIO_W     = 6,
    parameter int DWELL_W     = 8,
    parameter int DWELL_RESET = 4,
    parameter int RELOCK_CYC  = 16,
    parameter int VID_RESET   = 0,
    parameter int RATIO_RESET = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [1:0]         rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [VID_W-1:0]   vid_out,
    output logic [RATIO_W-1:0] ratio_out,
    output logic               busy,
    output logic               done,
    output logic               err
);
    localparam int RL_W = $clog2(RELOCK_CYC) + 1;
    localparam int TW   = (DWELL_W > RL_W) ? DWELL_W : RL_W;

    logic               start;
    logic [DWELL_W-1:0] dwell;
    logic               tmr_zero;
    logic               tmr_load;
    logic [TW-1:0]      tmr_val;

    vfs_regs #(
        .DATA_W(DATA_W), .VID_W(VID_W), .RATIO_W(RATIO_W),
        .DWELL_W(DWELL_W), .DWELL_RESET(DWELL_RESET)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .done(done), .cur_vid(vid_out), .cur_ratio(ratio_out),
        .start(start), .dwell(dwell), .err(err)
    );

    vfs_seq_fsm #(
        .DATA_W(DATA_W), .VID_W(VID_W), .RATIO_W(RATIO_W), .DWELL_W(DWELL_W),
        .TW(TW), .RELOCK_CYC(RELOCK_CYC), .VID_RESET(VID_RESET),
        .RATIO_RESET(RATIO_RESET)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_word(wr_data),
        .dwell(dwell), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .vid(vid_out), .ratio(ratio_out),
        .busy(busy), .done(done)
    );

    vfs_timer #(.TW(TW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .zero(tmr_zero)
    );
endmodule

// File: rtl/vfstep_ctrl_chk.sv
// Checker: protocol properties of the transition sequencer, seen at its ports.
// Assumes reset is held low for at least one clock edge at start-up.
module vfstep_ctrl_chk #(
    parameter int VID_W   = 6,
    parameter int RATIO_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [VID_W-1:0]   vid_out,
    input logic [RATIO_W-1:0] ratio_out,
    input logic               busy,
    input logic               done,
    input logic               err
);
    // R5
    vid_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out)) |->
            (vid_out == VID_W'($past(vid_out) + 1'b1) ||
             VID_W'(vid_out + 1'b1) == $past(vid_out)));

    // R2
    vid_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vid_out != $past(vid_out)) |-> $past(busy));

    // R2
    ratio_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_out != $past(ratio_out)) |-> $past(busy));

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    err_clear_only_by_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(wr_en && wr_addr == 2'd2));

    // R10
    err_set_by_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(wr_en && wr_addr == 2'd0 && busy));
endmodule

bind vfstep_ctrl vfstep_ctrl_chk #(.VID_W(VID_W), .RATIO_W(RATIO_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .vid_out(vid_out), .ratio_out(ratio_out), .busy(busy),
    .done(done), .err(err)
);

// File: tb/vfstep_ctrl_tb_top.sv
// Scoreboard bench: the driver task predicts each output change (kind, value,
// cycle gap) into a queue, and the monitor pops and compares it on every change.
module vfstep_ctrl_tb_top;
    localparam int RELOCK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [5:0]  vid_out;
    logic [5:0]  ratio_out;
    logic        busy, done, err;

    typedef struct { int kind; int val; int gap; string req; } ev_t; // kind 0 vid, 1 ratio
    ev_t exp_q[$];

    int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
    int m_vid = 0, m_ratio = 6, dwell = 4;
    logic [5:0] prev_vid, prev_ratio;
    logic mon_on = 1'b0;

    always #10 clk = ~clk;

    vfstep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .vid_out(vid_out), .ratio_out(ratio_out), .busy(busy),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_cmp(input int kind, input int val);
        ev_t e;
        int gap;
        gap = cyc - last_cyc;
        last_cyc = cyc;
        if (exp_q.size() == 0) begin
            chk(0, "R2 unexpected change", val, -1);
            return;
        end
        e = exp_q.pop_front();
        chk(e.kind == kind, {e.req, " change kind"}, kind, e.kind);
        chk(e.val == val, {e.req, " value"}, val, e.val);
        if (e.gap != 0) chk(gap == e.gap, {e.req, " gap"}, gap, e.gap);
    endtask

    // Monitor: detect output changes away from the clock edge and compare.
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (vid_out != prev_vid)     pop_cmp(0, int'(vid_out));
            if (ratio_out != prev_ratio) pop_cmp(1, int'(ratio_out));
        end
        prev_vid = vid_out;
        prev_ratio = ratio_out;
    end

    // Driver: predict the change list for a target, write it, wait for completion.
    task automatic move(input int v, input int r);
        int first = 1;
        int step;
        if (r < m_ratio) begin
            exp_q.push_back('{1, r, 0, "R4"});
            first = 0;
        end
        step = (v > m_vid) ? 1 : -1;
        for (int x = m_vid; x != v; x += step) begin
            int g;
            if (first == 1) g = 0;
            else if (r < m_ratio && x == m_vid) g = RELOCK + 1;
            else g = dwell + 1;
            exp_q.push_back('{0, x + step, g, (r == m_ratio) ? "R7" : "R6"});
            first = 0;
        end
        if (r > m_ratio) exp_q.push_back('{1, r, (v != m_vid) ? dwell + 2 : 0, "R3"});
        reg_wr(2'd0, 16'((r << 8) | v));
        if (v == m_vid && r == m_ratio) begin
            chk(done === 1'b1, "R8 done after equal target", int'(done), 1);
            chk(busy === 1'b0, "R8 busy stays low", int'(busy), 0);
            repeat (3) @(negedge clk);
        end else begin
            chk(busy === 1'b1, "R9 busy after accepted write", int'(busy), 1);
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(done === 1'b1, "R9 done at completion", int'(done), 1);
        end
        chk(exp_q.size() == 0, "R3 all predicted changes seen", exp_q.size(), 0);
        exp_q.delete();
        chk(vid_out == v[5:0], "R2 final vid", int'(vid_out), v);
        chk(ratio_out == r[5:0], "R2 final ratio", int'(ratio_out), r);
        rd_addr = 2'd3; #1;
        chk(rd_data == 16'((r << 8) | v), "R11 point readback", int'(rd_data), (r << 8) | v);
        m_vid = v; m_ratio = r;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(vid_out == 6'd0, "R1 reset vid", int'(vid_out), 0);
        chk(ratio_out == 6'd6, "R1 reset ratio", int'(ratio_out), 6);
        rd_addr = 2'd2; #1;
        chk(rd_data == 16'd0, "R1 reset status", int'(rd_data), 0);
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'd4, "R11 reset dwell readback", int'(rd_data), 4);
        mon_on = 1'b1;

        // R2: writes to other addresses start nothing
        reg_wr(2'd1, 16'd2); dwell = 2;
        rd_addr = 2'd1; #1;
        chk(rd_data == 16'd2, "R11 dwell readback", int'(rd_data), 2);
        repeat (4) @(negedge clk);
        chk(busy === 1'b0, "R2 no start on dwell write", int'(busy), 0);

        move(5, 10);   // R3 up move
        move(2, 7);    // R4 down move
        move(4, 7);    // R7 vid-only up
        move(1, 7);    // R7 vid-only down
        move(1, 7);    // R8 equal target
        move(0, 9);    // R3 ratio up while vid steps down
        reg_wr(2'd1, 16'd0); dwell = 0;
        move(6, 12);   // R6 dwell of zero
        move(3, 4);    // R4 down with dwell zero
        reg_wr(2'd1, 16'd3); dwell = 3;

        // R10: write during a move is dropped and sets a sticky error
        fork
            move(8, 11);
            begin
                repeat (6) @(negedge clk);
                chk(busy === 1'b1, "R10 busy before second write", int'(busy), 1);
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'((2 << 8) | 1);
                @(negedge clk);
                wr_en = 1'b0;
            end
        join
        chk(err === 1'b1, "R10 err set", int'(err), 1);
        repeat (5) @(negedge clk);
        chk(err === 1'b1, "R10 err sticky", int'(err), 1);
        rd_addr = 2'd2; #1;
        chk(rd_data == 16'd6, "R11 status err+done", int'(rd_data), 6);
        reg_wr(2'd2, 16'd0);
        chk(err === 1'b0, "R10 err cleared by status write", int'(err), 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule